// File: doc/BRIEF.md
# Differential Correlation Stream Selector

This block chooses the best of three candidate timing streams in a spread-spectrum receiver and hands on a phase-difference sum for carrier frequency estimation. Each stream delivers one complex matched-filter correlator value per symbol. A symbol-valid strobe is shared by all three streams. For every stream the block multiplies each new value by the complex conjugate of the value before it. It adds up these lag-one products over a window of `WIN_N` products.

When the window is complete, the block scales each stream's sum down to the output width and computes its energy as re² + im². It then reports the index of the most energetic stream together with that stream's scaled sum. A later stage takes the angle of the sum to estimate frequency offset. A window is opened by a start strobe. The first symbol taken after the start only primes the previous-value registers, so `WIN_N + 1` symbols yield `WIN_N` products.

Top module: `dcss_top`

## Requirements
- R1: After reset, `done_o` is 0, and `sel_o`, `sum_re_o` and `sum_im_o` are all 0.
- R2: The first symbol accepted after `start_i` only loads the previous-value registers and adds nothing to the sums.
- R3: Every later accepted symbol x on stream s adds conj(p)·x to that stream's sum, where p is the previous symbol of stream s: real part p_re·x_re + p_im·x_im, imaginary part p_re·x_im − p_im·x_re. Stream s sits at bits [s*12 +: 12] of `corr_re_i` and `corr_im_i`, as signed 12-bit values. The window closes after exactly `WIN_N` (default 8) products.
- R4: Each full-precision sum (28 bits by default) is arithmetically shifted right by 12 and its low 16 bits are kept. `sel_o` is the stream index (0 to 2) whose scaled sum has the largest re² + im². `sum_re_o` and `sum_im_o` are that stream's scaled sum.
- R5: When scaled energies tie, the lowest stream index among the tied streams wins.
- R6: `done_o` is high for exactly one cycle. The product-forming edge that takes the `WIN_N`-th product is followed by one more edge, and `done_o` rises at that second edge.
- R7: While no window is open, `sym_vld_i` and the correlator inputs have no effect: there is no `done_o`, and the outputs keep their values.
- R8: A `start_i` during an open window discards the partial sums and starts a new window.
- R9: When `start_i` and `sym_vld_i` are high in the same cycle, that symbol is the priming symbol of the new window.
- R10: `sel_o`, `sum_re_o` and `sum_im_o` change only on the edge that raises `done_o`, and they hold until the next such edge.
- R11: Cycles with `sym_vld_i` low do not change the accumulation, whatever the correlator inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new accumulation window |
| sym_vld_i | input | 1 | Symbol strobe; correlator inputs valid |
| corr_re_i | input | 36 | Real parts of three signed 12-bit correlator values |
| corr_im_i | input | 36 | Imaginary parts of three signed 12-bit correlator values |
| done_o | output | 1 | One-cycle pulse when a result is presented |
| sel_o | output | 2 | Index of the winning stream |
| sum_re_o | output | 16 | Scaled real part of the winner's sum |
| sum_im_o | output | 16 | Scaled imaginary part of the winner's sum |

## Verification
The collision that matters is a new start strobe arriving together with a priming symbol on the very cycle the finished window's result is being latched. Two things happen on that one edge: the accumulators clear for the new window, and the output registers read the old sums. The bench provokes this by chaining one window straight into the next, with the chained start carrying a symbol. It judges the outcome twice. The pulse reported on that edge must match the bench model of the old window. The following window's result must equal the model built only from the chained priming symbol and the symbols after it.

// File: rtl/dcss_pkg.sv
package dcss_pkg;

    // Window control state
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no window open, symbols ignored
        ST_ARM  = 2'd1,   // window open, waiting for priming symbol
        ST_ACC  = 2'd2    // forming and adding lag-one products
    } dcss_state_e;

endpackage

// File: rtl/dcss_diff_acc.sv
module dcss_diff_acc #(
    parameter int IN_W  = 12,
    parameter int ACC_W = 28
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    ld_i,
    input  logic                    en_i,
    input  logic signed [IN_W-1:0]  x_re_i,
    input  logic signed [IN_W-1:0]  x_im_i,
    output logic signed [ACC_W-1:0] acc_re_o,
    output logic signed [ACC_W-1:0] acc_im_o
);
    localparam int MUL_W = 2 * IN_W;

    typedef struct packed {
        logic signed [IN_W-1:0]  prev_re;
        logic signed [IN_W-1:0]  prev_im;
        logic signed [ACC_W-1:0] acc_re;
        logic signed [ACC_W-1:0] acc_im;
    } acc_reg_t;

    acc_reg_t r_d, r_q;

    logic signed [MUL_W-1:0] m_rr, m_ii, m_ri, m_ir;

    // conj(prev) * x
    assign m_rr = MUL_W'(r_q.prev_re) * MUL_W'(x_re_i);
    assign m_ii = MUL_W'(r_q.prev_im) * MUL_W'(x_im_i);
    assign m_ri = MUL_W'(r_q.prev_re) * MUL_W'(x_im_i);
    assign m_ir = MUL_W'(r_q.prev_im) * MUL_W'(x_re_i);

    always_comb begin
        r_d = r_q;
        if (clr_i) begin
            r_d.acc_re = '0;
            r_d.acc_im = '0;
        end
        if (ld_i || en_i) begin
            r_d.prev_re = x_re_i;
            r_d.prev_im = x_im_i;
        end
        if (en_i) begin
            r_d.acc_re = r_q.acc_re + ACC_W'(m_rr) + ACC_W'(m_ii);
            r_d.acc_im = r_q.acc_im + ACC_W'(m_ri) - ACC_W'(m_ir);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign acc_re_o = r_q.acc_re;
    assign acc_im_o = r_q.acc_im;

endmodule

// File: rtl/dcss_pick.sv
module dcss_pick #(
    parameter int NSTR  = 3,
    parameter int ACC_W = 28,
    parameter int OUT_W = 16,
    parameter int SHIFT = 12,
    parameter int SEL_W = 2
) (
    input  logic [NSTR*ACC_W-1:0]   acc_re_i,
    input  logic [NSTR*ACC_W-1:0]   acc_im_i,
    output logic [SEL_W-1:0]        sel_o,
    output logic signed [OUT_W-1:0] re_o,
    output logic signed [OUT_W-1:0] im_o
);
    localparam int SQ_W  = 2 * OUT_W;
    localparam int MAG_W = SQ_W + 1;

    logic signed [OUT_W-1:0] tr_re [NSTR];
    logic signed [OUT_W-1:0] tr_im [NSTR];
    logic [MAG_W-1:0]        mag   [NSTR];

    // Shift/truncate each sum, then full-precision energy
    for (genvar g = 0; g < NSTR; g++) begin : g_str
        logic signed [SQ_W-1:0] sq_re, sq_im;
        assign tr_re[g] = $signed(acc_re_i[g*ACC_W+SHIFT +: OUT_W]);
        assign tr_im[g] = $signed(acc_im_i[g*ACC_W+SHIFT +: OUT_W]);
        assign sq_re    = SQ_W'(tr_re[g]) * SQ_W'(tr_re[g]);
        assign sq_im    = SQ_W'(tr_im[g]) * SQ_W'(tr_im[g]);
        assign mag[g]   = {1'b0, sq_re} + {1'b0, sq_im};
    end

    // Strict greater-than keeps the lowest index on ties
    always_comb begin
        logic [MAG_W-1:0] best;
        best  = mag[0];
        sel_o = '0;
        re_o  = tr_re[0];
        im_o  = tr_im[0];
        for (int s = 1; s < NSTR; s++) begin
            if (mag[s] > best) begin
                best  = mag[s];
                sel_o = SEL_W'(s);
                re_o  = tr_re[s];
                im_o  = tr_im[s];
            end
        end
    end

endmodule

// File: rtl/dcss_top.sv
module dcss_top
    import dcss_pkg::*;
#(
    parameter int NSTR  = 3,
    parameter int IN_W  = 12,
    parameter int OUT_W = 16,
    parameter int WIN_N = 8,
    localparam int SEL_W = (NSTR > 1) ? $clog2(NSTR) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    sym_vld_i,
    input  logic [NSTR*IN_W-1:0]    corr_re_i,
    input  logic [NSTR*IN_W-1:0]    corr_im_i,
    output logic                    done_o,
    output logic [SEL_W-1:0]        sel_o,
    output logic signed [OUT_W-1:0] sum_re_o,
    output logic signed [OUT_W-1:0] sum_im_o
);
    localparam int PROD_W = 2 * IN_W + 1;
    localparam int ACC_W  = PROD_W + $clog2(WIN_N);
    localparam int SHIFT  = (ACC_W > OUT_W) ? ACC_W - OUT_W : 0;
    localparam int CNT_W  = (WIN_N > 1) ? $clog2(WIN_N) : 1;

    typedef struct packed {
        dcss_state_e             st;
        logic [CNT_W-1:0]        cnt;
        logic                    fin;
        logic                    done;
        logic [SEL_W-1:0]        sel;
        logic signed [OUT_W-1:0] sum_re;
        logic signed [OUT_W-1:0] sum_im;
    } ctl_reg_t;

    ctl_reg_t r_d, r_q;

    logic acc_clr, acc_ld, acc_en;
    logic [NSTR*ACC_W-1:0] acc_re_all, acc_im_all;
    logic [SEL_W-1:0]        pick_sel;
    logic signed [OUT_W-1:0] pick_re, pick_im;

    // Mirrors of control state for the bound checker
    dcss_state_e ctl_state;
    logic        ctl_fin;
    assign ctl_state = r_q.st;
    assign ctl_fin   = r_q.fin;

    for (genvar g = 0; g < NSTR; g++) begin : g_acc
        logic signed [ACC_W-1:0] a_re, a_im;
        dcss_diff_acc #(
            .IN_W (IN_W),
            .ACC_W(ACC_W)
        ) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (acc_clr),
            .ld_i    (acc_ld),
            .en_i    (acc_en),
            .x_re_i  ($signed(corr_re_i[g*IN_W +: IN_W])),
            .x_im_i  ($signed(corr_im_i[g*IN_W +: IN_W])),
            .acc_re_o(a_re),
            .acc_im_o(a_im)
        );
        assign acc_re_all[g*ACC_W +: ACC_W] = a_re;
        assign acc_im_all[g*ACC_W +: ACC_W] = a_im;
    end

    dcss_pick #(
        .NSTR (NSTR),
        .ACC_W(ACC_W),
        .OUT_W(OUT_W),
        .SHIFT(SHIFT),
        .SEL_W(SEL_W)
    ) u_pick (
        .acc_re_i(acc_re_all),
        .acc_im_i(acc_im_all),
        .sel_o   (pick_sel),
        .re_o    (pick_re),
        .im_o    (pick_im)
    );

    always_comb begin
        r_d     = r_q;
        r_d.fin  = 1'b0;
        r_d.done = 1'b0;
        acc_clr = 1'b0;
        acc_ld  = 1'b0;
        acc_en  = 1'b0;

        if (start_i) begin
            acc_clr = 1'b1;
            r_d.cnt = '0;
            if (sym_vld_i) begin
                acc_ld = 1'b1;
                r_d.st = ST_ACC;
            end else begin
                r_d.st = ST_ARM;
            end
        end else begin
            unique case (r_q.st)
                ST_ARM: begin
                    if (sym_vld_i) begin
                        acc_ld = 1'b1;
                        r_d.st = ST_ACC;
                    end
                end
                ST_ACC: begin
                    if (sym_vld_i) begin
                        acc_en = 1'b1;
                        if (r_q.cnt == CNT_W'(WIN_N - 1)) begin
                            r_d.st  = ST_IDLE;
                            r_d.cnt = '0;
                            r_d.fin = 1'b1;
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end

        // Result latch reads the sums before any clear on this edge
        if (r_q.fin) begin
            r_d.done   = 1'b1;
            r_d.sel    = pick_sel;
            r_d.sum_re = pick_re;
            r_d.sum_im = pick_im;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o   = r_q.done;
    assign sel_o    = r_q.sel;
    assign sum_re_o = r_q.sum_re;
    assign sum_im_o = r_q.sum_im;

endmodule

// File: rtl/dcss_checker.sv
module dcss_checker
    import dcss_pkg::*;
#(
    parameter int NSTR  = 3,
    parameter int OUT_W = 16,
    parameter int SEL_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              sym_vld_i,
    input logic              done_o,
    input logic [SEL_W-1:0]  sel_o,
    input logic [OUT_W-1:0]  sum_re_o,
    input logic [OUT_W-1:0]  sum_im_o,
    input dcss_state_e       ctl_state,
    input logic              ctl_fin
);

    assert_done_follows_fin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_fin |=> done_o);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_sel_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sel_o) < NSTR);

    assert_hold_between_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(sel_o) && $stable(sum_re_o) && $stable(sum_im_o)));

    assert_idle_ignores_sym_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == ST_IDLE && !start_i) |=> (ctl_state == ST_IDLE && !ctl_fin));

    assert_restart_opens_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (ctl_state != ST_IDLE && !ctl_fin));

    assert_start_with_sym_primes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && sym_vld_i) |=> ctl_state == ST_ACC);

endmodule

bind dcss_top dcss_checker #(
    .NSTR (NSTR),
    .OUT_W(OUT_W),
    .SEL_W(SEL_W)
) u_dcss_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .sym_vld_i(sym_vld_i),
    .done_o   (done_o),
    .sel_o    (sel_o),
    .sum_re_o (sum_re_o),
    .sum_im_o (sum_im_o),
    .ctl_state(ctl_state),
    .ctl_fin  (ctl_fin)
);

// File: tb/dcss_top_bench.sv
`timescale 1ns/100ps
module dcss_top_bench;
    localparam int NS    = 3;
    localparam int IW    = 12;
    localparam int OW    = 16;
    localparam int N     = 8;
    localparam int SHIFT = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic sym_vld_i = 1'b0;
    logic [NS*IW-1:0] corr_re_i = '0;
    logic [NS*IW-1:0] corr_im_i = '0;
    logic done_o;
    logic [1:0] sel_o;
    logic signed [OW-1:0] sum_re_o, sum_im_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    int d_re [NS][N+1];
    int d_im [NS][N+1];
    int e_sel;
    longint e_re, e_im;

    always #2.5 clk = ~clk;

    dcss_top #(.NSTR(NS), .IN_W(IW), .OUT_W(OW), .WIN_N(N)) u_dcss_top (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sym_vld_i(sym_vld_i),
        .corr_re_i(corr_re_i), .corr_im_i(corr_im_i), .done_o(done_o),
        .sel_o(sel_o), .sum_re_o(sum_re_o), .sum_im_o(sum_im_o));

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd12();
        return int'($urandom_range(4095)) - 2048;
    endfunction

    task automatic put(int k);
        for (int s = 0; s < NS; s++) begin
            corr_re_i[s*IW +: IW] = IW'(d_re[s][k]);
            corr_im_i[s*IW +: IW] = IW'(d_im[s][k]);
        end
    endtask

    task automatic junk();
        for (int s = 0; s < NS; s++) begin
            corr_re_i[s*IW +: IW] = IW'(rnd12());
            corr_im_i[s*IW +: IW] = IW'(rnd12());
        end
    endtask

    // one clock: drive, take the edge, return 1 ns after it
    task automatic cyc(bit st, bit sv);
        start_i = st;
        sym_vld_i = sv;
        @(posedge clk);
        #1;
        start_i = 1'b0;
        sym_vld_i = 1'b0;
    endtask

    // model per R3/R4/R5
    task automatic model();
        longint best;
        best = -1;
        for (int s = 0; s < NS; s++) begin
            longint ar, ai, m;
            logic signed [OW-1:0] tr, ti;
            ar = 0; ai = 0;
            for (int k = 1; k <= N; k++) begin
                ar += longint'(d_re[s][k-1]) * d_re[s][k] + longint'(d_im[s][k-1]) * d_im[s][k];
                ai += longint'(d_re[s][k-1]) * d_im[s][k] - longint'(d_im[s][k-1]) * d_re[s][k];
            end
            tr = OW'(ar >>> SHIFT);
            ti = OW'(ai >>> SHIFT);
            m = longint'(tr) * tr + longint'(ti) * ti;
            if (m > best) begin
                best = m; e_sel = s; e_re = tr; e_im = ti;
            end
        end
    endtask

    // mode 0 random, 1 all equal (tie), 2 streams 1 and 2 equal and strong
    task automatic gen(int mode, bit keep_prime);
        for (int k = (keep_prime ? 1 : 0); k <= N; k++) begin
            for (int s = 0; s < NS; s++) begin
                d_re[s][k] = rnd12();
                d_im[s][k] = rnd12();
            end
            if (mode == 1) begin
                for (int s = 1; s < NS; s++) begin
                    d_re[s][k] = d_re[0][k]; d_im[s][k] = d_im[0][k];
                end
            end else if (mode == 2) begin
                d_re[0][k] = int'($urandom_range(30)) - 15;
                d_im[0][k] = int'($urandom_range(30)) - 15;
                d_re[2][k] = d_re[1][k]; d_im[2][k] = d_im[1][k];
            end
        end
    endtask

    // run a window; chain=1 opens the next window (start + priming symbol)
    // on the cycle the result is latched
    task automatic window(string tag, bit with_sym, bit skip_start, int gaps, bit chain);
        if (!skip_start) begin
            put(0);
            if (with_sym) cyc(1, 1);
            else begin
                cyc(1, 0);
                junk(); cyc(0, 0);
                put(0); cyc(0, 1);
            end
        end
        for (int k = 1; k <= N; k++) begin
            int g;
            g = (gaps != 0) ? int'($urandom_range(gaps)) : 0;
            for (int i = 0; i < g; i++) begin
                junk(); cyc(0, 0);   // R11: unstrobed data ignored
            end
            put(k);
            cyc(0, 1);
        end
        model();
        chk({tag, " R6 no done on last product edge"}, done_o, 0);
        if (chain) begin
            int nr [NS];
            int ni [NS];
            for (int s = 0; s < NS; s++) begin
                nr[s] = rnd12(); ni[s] = rnd12();
                corr_re_i[s*IW +: IW] = IW'(nr[s]);
                corr_im_i[s*IW +: IW] = IW'(ni[s]);
            end
            cyc(1, 1);
            for (int s = 0; s < NS; s++) begin
                d_re[s][0] = nr[s]; d_im[s][0] = ni[s];
            end
        end else begin
            cyc(0, 0);
        end
        chk({tag, " R6 done pulse"}, done_o, 1);
        chk({tag, " R4 sel"}, sel_o, e_sel);
        chk({tag, " R3 sum_re"}, sum_re_o, e_re);
        chk({tag, " R3 sum_im"}, sum_im_o, e_im);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 done in reset", done_o, 0);
        rst_n = 1'b1;
        cyc(0, 0);
        chk("R1 done after reset", done_o, 0);
        chk("R1 sel after reset", sel_o, 0);
        chk("R1 sum_re after reset", sum_re_o, 0);
        chk("R1 sum_im after reset", sum_im_o, 0);

        // R2/R3: separate start, priming symbol loads only
        gen(0, 0);
        window("R2 separate-prime", 0, 0, 0, 0);
        cyc(0, 0);
        chk("R6 single-cycle done", done_o, 0);

        // R7: symbols while idle are ignored
        for (int i = 0; i < 3; i++) begin
            longint hs, hr, hi;
            hs = sel_o; hr = sum_re_o; hi = sum_im_o;
            junk(); cyc(0, 1);
            chk("R7 idle sym no done", done_o, 0);
            chk("R7 idle sel held", sel_o, hs);
            chk("R7 idle sum_re held", sum_re_o, hr);
            chk("R10 idle sum_im held", sum_im_o, hi);
        end

        // R9 + R11: start with symbol, random gaps with junk
        for (int w = 0; w < 6; w++) begin
            gen(0, 0);
            window("R9 R11 random", 1, 0, 2, 0);
        end

        // R8: restart after partial junk window
        junk(); cyc(1, 1);
        for (int i = 0; i < 4; i++) begin
            junk(); cyc(0, 1);
        end
        gen(0, 0);
        window("R8 restart", 0, 0, 1, 0);

        // R5: exact tie across all streams -> index 0
        gen(1, 0);
        window("R5 tie all", 1, 0, 0, 0);
        chk("R5 tie picks stream 0", sel_o, 0);

        // R5: streams 1 and 2 tie, stronger than 0 -> index 1
        gen(2, 0);
        window("R5 tie upper", 1, 0, 0, 0);

        // Same-cycle: new start+prime on the result-latch cycle
        gen(0, 0);
        window("R9 chain-a", 1, 0, 0, 1);
        gen(0, 1);
        window("R9 chain-b", 1, 1, 1, 1);
        gen(0, 1);
        window("R9 chain-c", 1, 1, 0, 0);

        // More random coverage
        for (int w = 0; w < 8; w++) begin
            gen(w % 3, 0);
            window("R4 mixed", w[0], 0, 2, 0);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule